// File: doc/BRIEF.md
# Serial-Load DAC Register Front-End

This block is the digital front end of a 16-bit serial-input voltage DAC. A host shifts a code word in over a three-wire serial link (clock, data, active-low select). The word lands in a shift register and then moves into an input-holding register. From there it reaches the DAC register either at the end of the frame or later, through an active-low load strobe. An active-low clear input zeroes the stored codes and blocks the load strobe for as long as it is held low. The DAC register directly drives the switch-control word of a segmented converter. The four most significant bits become a 15-line thermometer code for equal-weight coarse segments, and the low 12 bits drive the binary fine-ladder switches.

All five pins are asynchronous to the block. Each one passes through a two-flop synchronizer into a fast system clock domain, and edges are detected there. The serial clock must therefore stay in each phase for at least three system clock cycles. The code path is not a stream: there is no valid/ready handshake and no back-pressure. The pins are plain levels, and the outputs are plain registered levels that change only as described below. A 5-bit frame bit counter is exported for status only; it has no effect on the shift.

Top module: `dac_serial_front`

## Requirements
- R1: After reset the DAC code, the segment word, the ladder word and the frame bit count are all zero.
- R2: While select is low, each rising serial clock shifts the data bit in at the LSB end, so words arrive MSB first. On the rising edge of select with the load strobe low, the DAC register takes the shifted 16-bit word.
- R3: Serial clock and data activity while select is high changes neither the shift register nor any stored code. A following frame with no clock edges therefore transfers the unchanged prior word.
- R4: When the load strobe is high at the rising edge of select, only the input register is written and the DAC code is unchanged. A later low level on the load strobe, with no serial clock activity, copies the input register into the DAC register.
- R5: A frame of more than 16 clock edges keeps the last 16 bits received.
- R6: A frame of k < 16 clock edges yields {previous word[15-k:0], the k new bits}.
- R7: A falling edge on clear sets the shift register, the input register and the DAC register to zero.
- R8: While clear is low, the load strobe has no effect: the DAC code stays zero through frame ends and strobes, while the input register still accepts frames. After clear returns high, a strobe loads the input register.
- R9: Segment output bit i is 1 exactly when DAC code bits [15:12], read as an unsigned number, exceed i (i = 0..14). The ladder output equals DAC code bits [11:0].
- R10: The frame bit count is cleared on the falling edge of select, rises by one for each accepted serial clock edge, and saturates at 16. It holds its value after select rises.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock that samples all pins |
| rst_n | input | 1 | Active-low synchronous-release reset |
| sclk_i | input | 1 | Serial bit clock, asynchronous |
| sdi_i | input | 1 | Serial data, sampled on rising sclk_i |
| sel_n_i | input | 1 | Active-low frame select |
| load_n_i | input | 1 | Active-low DAC register load strobe (level) |
| clr_n_i | input | 1 | Active-low clear, acting on its falling edge and blocking loads while low |
| dac_code_o | output | 16 | Current DAC register contents |
| seg_therm_o | output | 15 | Thermometer-coded coarse segment enables |
| ladder_o | output | 12 | Fine binary ladder switch drive |
| frame_bits_o | output | 5 | Accepted bits in the current/last frame, saturating at 16 |

## Verification
The hardest situation to reach is an input register that differs from the DAC register while clear is active, because the input register is not visible at the ports. The stimulus keeps the strobe high across a frame end so that the two registers diverge. It then asserts clear, runs frames and strobes while clear is held, and releases clear. A final strobe then reveals the input register through the DAC code. A related case is a select frame with zero clock edges, which exposes the shift register: this shows that clocks issued while select was high left it unchanged, and that clear zeroed it.

// File: rtl/dsf_pkg.sv
package dsf_pkg;
  // Synchronized pin bundle, order fixed for packing
  typedef struct packed {
    logic cs_n;
    logic sclk;
    logic din;
    logic ld_n;
    logic clr_n;
  } pins_t;

  localparam int PIN_W = $bits(pins_t);
  localparam pins_t PINS_IDLE = '{cs_n: 1'b1, sclk: 1'b0, din: 1'b0, ld_n: 1'b1, clr_n: 1'b1};
endpackage

// File: rtl/dsf_sync.sv
module dsf_sync #(
  parameter int W = 5,
  parameter int STAGES = 2,
  parameter logic [W-1:0] RST_VAL = '0
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [W-1:0] d,
  output logic [W-1:0] q
);
  logic [W-1:0] st [STAGES];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      for (int i = 0; i < STAGES; i++) st[i] <= RST_VAL;
    end else begin
      st[0] <= d;
      for (int i = 1; i < STAGES; i++) st[i] <= st[i-1];
    end
  end

  assign q = st[STAGES-1];
endmodule

// File: rtl/dsf_shifter.sv
module dsf_shifter #(
  parameter int DW = 16,
  localparam int CW = $clog2(DW + 1)
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          shift_en,
  input  logic          bit_in,
  input  logic          clear,
  input  logic          frame_start,
  output logic [DW-1:0] word,
  output logic [CW-1:0] count
);
  localparam logic [CW-1:0] CMAX = CW'(DW);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      word <= '0;
    end else if (clear) begin
      word <= '0;
    end else if (shift_en) begin
      word <= {word[DW-2:0], bit_in};
    end
  end

  // status only: never gates the shift
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      count <= '0;
    end else if (frame_start) begin
      count <= shift_en ? CW'(1) : '0;
    end else if (shift_en && count != CMAX) begin
      count <= count + CW'(1);
    end
  end
endmodule

// File: rtl/dsf_seg_decode.sv
module dsf_seg_decode #(
  parameter int DW = 16,
  parameter int COARSE = 4,
  localparam int NSEG = (1 << COARSE) - 1,
  localparam int FINE = DW - COARSE
) (
  input  logic [DW-1:0]   code,
  output logic [NSEG-1:0] seg,
  output logic [FINE-1:0] ladder
);
  logic [COARSE-1:0] top;
  assign top = code[DW-1:FINE];

  for (genvar i = 0; i < NSEG; i++) begin : g_seg
    assign seg[i] = (top > COARSE'(i));
  end

  assign ladder = code[FINE-1:0];
endmodule

// File: rtl/dac_serial_front.sv
module dac_serial_front
  import dsf_pkg::*;
#(
  parameter int DW = 16,
  parameter int COARSE = 4,
  parameter int SYNC_STAGES = 2,
  localparam int NSEG = (1 << COARSE) - 1,
  localparam int FINE = DW - COARSE,
  localparam int CW = $clog2(DW + 1)
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            sclk_i,
  input  logic            sdi_i,
  input  logic            sel_n_i,
  input  logic            load_n_i,
  input  logic            clr_n_i,
  output logic [DW-1:0]   dac_code_o,
  output logic [NSEG-1:0] seg_therm_o,
  output logic [FINE-1:0] ladder_o,
  output logic [CW-1:0]   frame_bits_o
);
  pins_t raw, syn, prv;
  logic [PIN_W-1:0] syn_vec;

  assign raw = {sel_n_i, sclk_i, sdi_i, load_n_i, clr_n_i};

  dsf_sync #(.W(PIN_W), .STAGES(SYNC_STAGES), .RST_VAL(PINS_IDLE)) u_sync (
    .clk(clk), .rst_n(rst_n), .d(raw), .q(syn_vec)
  );
  assign syn = pins_t'(syn_vec);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) prv <= PINS_IDLE;
    else        prv <= syn;
  end

  logic cs_lvl, cs_prev, ld_lvl, clr_lvl;
  logic sclk_rise, cs_rise, cs_fall, clr_fall, shift_en;
  assign cs_lvl    = syn.cs_n;
  assign cs_prev   = prv.cs_n;
  assign ld_lvl    = syn.ld_n;
  assign clr_lvl   = syn.clr_n;
  assign sclk_rise = syn.sclk & ~prv.sclk;
  assign cs_rise   = cs_lvl & ~cs_prev;
  assign cs_fall   = ~cs_lvl & cs_prev;
  assign clr_fall  = ~clr_lvl & prv.clr_n;
  assign shift_en  = sclk_rise & ~cs_lvl;

  logic [DW-1:0] shift_word, in_reg, dac_reg;
  logic [CW-1:0] bit_cnt;

  dsf_shifter #(.DW(DW)) u_shift (
    .clk(clk), .rst_n(rst_n), .shift_en(shift_en), .bit_in(syn.din),
    .clear(clr_fall), .frame_start(cs_fall), .word(shift_word), .count(bit_cnt)
  );

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      in_reg  <= '0;
      dac_reg <= '0;
    end else if (clr_fall) begin
      in_reg  <= '0;
      dac_reg <= '0;
    end else begin
      if (cs_rise) in_reg <= shift_word;
      if (!ld_lvl && clr_lvl) dac_reg <= cs_rise ? shift_word : in_reg;
    end
  end

  dsf_seg_decode #(.DW(DW), .COARSE(COARSE)) u_dec (
    .code(dac_reg), .seg(seg_therm_o), .ladder(ladder_o)
  );

  assign dac_code_o   = dac_reg;
  assign frame_bits_o = bit_cnt;
endmodule

// File: rtl/dac_serial_front_checker.sv
module dac_serial_front_checker #(
  parameter int DW = 16,
  parameter int NSEG = 15,
  parameter int CW = 5
) (
  input logic            clk,
  input logic            rst_n,
  input logic            cs_lvl,
  input logic            cs_prev,
  input logic            ld_lvl,
  input logic            clr_lvl,
  input logic [DW-1:0]   shift_word,
  input logic [CW-1:0]   bit_cnt,
  input logic [DW-1:0]   dac_code_o,
  input logic [NSEG-1:0] seg_therm_o
);
  localparam int TOPB = DW - 4;

  // R3: with select high throughout and no clear, the shift register holds
  p_shift_idle_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (cs_lvl && cs_prev && clr_lvl) |=> $stable(shift_word));

  // R4: with the strobe high and clear high the DAC code holds
  p_dac_hold_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (ld_lvl && clr_lvl) |=> $stable(dac_code_o));

  // R8: while clear is low the DAC code is zero one cycle later
  p_clr_zero_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (!clr_lvl) |=> (dac_code_o == '0));

  // R9: number of active segments equals the top field of the code
  p_seg_count_r9: assert property (@(posedge clk) disable iff (!rst_n)
    $countones(seg_therm_o) == int'(dac_code_o[DW-1:TOPB]));

  // R9: segments form a contiguous run from bit 0
  p_seg_shape_r9: assert property (@(posedge clk) disable iff (!rst_n)
    ((seg_therm_o + NSEG'(1)) & seg_therm_o) == '0);

  // R10: count never passes the word width
  p_cnt_sat_r10: assert property (@(posedge clk) disable iff (!rst_n)
    bit_cnt <= CW'(DW));

  // R10: a new frame starts from zero or one
  p_cnt_start_r10: assert property (@(posedge clk) disable iff (!rst_n)
    (!cs_lvl && cs_prev) |=> (bit_cnt <= CW'(1)));
endmodule

bind dac_serial_front dac_serial_front_checker #(.DW(DW), .NSEG(NSEG), .CW(CW)) u_chk (
  .clk(clk), .rst_n(rst_n), .cs_lvl(cs_lvl), .cs_prev(cs_prev), .ld_lvl(ld_lvl),
  .clr_lvl(clr_lvl), .shift_word(shift_word), .bit_cnt(bit_cnt),
  .dac_code_o(dac_code_o), .seg_therm_o(seg_therm_o)
);

// File: tb/dac_serial_front_bench.sv
module dac_serial_front_bench;
  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic sclk = 1'b0, sdi = 1'b0, sel_n = 1'b1, load_n = 1'b1, clr_n = 1'b1;
  logic [15:0] dac;
  logic [14:0] seg;
  logic [11:0] lad;
  logic [4:0]  fbits;

  int checks = 0;
  int failures = 0;
  logic [15:0] m_shift = '0, m_in = '0, m_dac = '0;

  always #5 clk = ~clk;

  dac_serial_front u_dac_serial_front (
    .clk(clk), .rst_n(rst_n), .sclk_i(sclk), .sdi_i(sdi), .sel_n_i(sel_n),
    .load_n_i(load_n), .clr_n_i(clr_n), .dac_code_o(dac), .seg_therm_o(seg),
    .ladder_o(lad), .frame_bits_o(fbits)
  );

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      failures++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic idle(input int n);
    repeat (n) @(negedge clk);
  endtask

  // R9 expected outputs from the model code
  task automatic chk_out(input string req);
    logic [14:0] eseg;
    eseg = 15'((32'd1 << m_dac[15:12]) - 1);
    chk(req, 32'(dac), 32'(m_dac));
    chk({req, "/R9 seg"}, 32'(seg), 32'(eseg));
    chk({req, "/R9 ladder"}, 32'(lad), 32'(m_dac[11:0]));
  endtask

  task automatic frame(input logic [31:0] data, input int nbits, input bit ld_low);
    if (ld_low) load_n = 1'b0;
    sel_n = 1'b0;
    idle(5);
    chk("R10 clear on select fall", 32'(fbits), 32'd0);
    for (int i = 0; i < nbits; i++) begin
      sdi = data[nbits-1-i];
      idle(3);
      sclk = 1'b1;
      idle(3);
      sclk = 1'b0;
      m_shift = {m_shift[14:0], data[nbits-1-i]};
    end
    idle(3);
    sel_n = 1'b1;
    idle(6);
    m_in = m_shift;
    if (ld_low && clr_n) m_dac = m_in;
    load_n = 1'b1;
    idle(4);
    chk("R10 count", 32'(fbits), 32'((nbits > 16) ? 16 : nbits));
  endtask

  task automatic strobe();
    load_n = 1'b0;
    idle(6);
    if (clr_n) m_dac = m_in;
    load_n = 1'b1;
    idle(4);
  endtask

  initial begin
    #2_000_000;
    failures++;
    $display("FAIL watchdog actual=running expected=done");
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin
    idle(3);
    rst_n = 1'b1;
    idle(4);
    // R1
    chk("R1 dac", 32'(dac), 0);
    chk("R1 seg", 32'(seg), 0);
    chk("R1 ladder", 32'(lad), 0);
    chk("R1 count", 32'(fbits), 0);

    // R2 + R9: sweep every coarse field value with varied fine bits
    for (int n = 0; n < 16; n++) begin
      frame(32'({4'(n), 12'(32'h5A3 ^ (n * 273))}), 16, 1'b1);
      chk_out("R2 load");
    end
    frame(32'hFFFF, 16, 1'b1); chk_out("R2 ones");
    frame(32'h8000, 16, 1'b1); chk_out("R2 msb");
    frame(32'h0001, 16, 1'b1); chk_out("R2 lsb");

    // R3: activity with select high, strobe low
    load_n = 1'b0;
    for (int i = 0; i < 16; i++) begin
      sdi = ~sdi; idle(3); sclk = 1'b1; idle(3); sclk = 1'b0;
    end
    idle(4);
    load_n = 1'b1;
    chk_out("R3 dac untouched");
    frame(32'h0, 0, 1'b1);
    chk_out("R3 shift untouched");

    // R4: strobe high at frame end
    frame(32'h3C69, 16, 1'b0);
    chk_out("R4 dac unchanged");
    chk("R4 still old", 32'(dac), 32'h0001);
    strobe();
    chk_out("R4 strobe copy");
    chk("R4 new word", 32'(dac), 32'h3C69);

    // R5: over-length frame
    frame(32'hB_7E41, 20, 1'b1);
    chk_out("R5 last sixteen");
    chk("R5 value", 32'(dac), 32'h7E41);

    // R6: short frame keeps earlier bits
    frame(32'h15, 5, 1'b1);
    chk_out("R6 short");
    chk("R6 value", 32'(dac), 32'hC835);

    // R7: clear zeroes input and shift registers too
    frame(32'h9ABC, 16, 1'b0);
    clr_n = 1'b0; idle(6);
    m_shift = '0; m_in = '0; m_dac = '0;
    chk_out("R7 dac cleared");
    clr_n = 1'b1; idle(6);
    strobe();
    chk_out("R7 input cleared");
    frame(32'h0, 0, 1'b1);
    chk_out("R7 shift cleared");

    // R8: strobe ignored while clear is low
    frame(32'h4D2F, 16, 1'b1);
    clr_n = 1'b0; idle(6);
    m_shift = '0; m_in = '0; m_dac = '0;
    frame(32'hE17B, 16, 1'b1);
    chk_out("R8 frame end blocked");
    frame(32'h62D0, 16, 1'b0);
    strobe();
    chk_out("R8 strobe blocked");
    chk("R8 zero", 32'(dac), 0);
    clr_n = 1'b1; idle(6);
    chk_out("R8 release");
    strobe();
    chk_out("R8 load after release");
    chk("R8 value", 32'(dac), 32'h62D0);

    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule